// File: doc/BRIEF.md
# Bidirectional Gray/Binary Code Translator with Counting Source

This block turns an 8-bit word into either its reflected Gray code or its binary meaning, and delivers the result through a register. The word comes from one of two sources: an internal up-counter that free-runs while enabled, or an external code bus. The counter is the built-in test source: with it selected and the Gray direction chosen, the registered output walks the Gray sequence one code per clock.

Two inputs choose one of four operating modes. Each mode is the pair {source select, direction select}:

- `MODE_CNT_GRAY` (00): counter value, Gray-encoded.
- `MODE_CNT_BIN` (01): counter value, read as Gray and decoded to binary.
- `MODE_EXT_GRAY` (10): external word, Gray-encoded.
- `MODE_EXT_BIN` (11): external word, decoded to binary.

The mode can change on any clock. There are no other transitions. The converters are pure combinational logic. Only the counter and the output register hold state, and both are cleared by a synchronous reset.

Top module: `gray_xcoder`

## Requirements
- R1: When `rst` is high at a rising edge, the counter and `code_q` both become 0 at that edge. After `rst` is released, the counter starts again from 0.
- R2: While `cnt_en` is high, the counter rises by exactly 1 per rising edge and wraps from 255 to 0.
- R3: While `cnt_en` is low, the counter keeps its value. With the counter selected and the mode fixed, `code_q` then stays constant.
- R4: When `src_ext`=0 the counter feeds the converters. When `src_ext`=1, `ext_code` feeds them.
- R5: When `out_bin`=0, `code_q` receives the Gray code of the source word s: bit i equals s[i] XOR s[i+1] for i below 7, and bit 7 equals s[7].
- R6: When `out_bin`=1, `code_q` receives the binary decode of the source word s, read as Gray: bit 7 equals s[7], and each lower bit i equals decoded bit i+1 XOR s[i].
- R7: `code_q` changes only at a rising edge. It shows the result for the inputs sampled at that edge, which gives one cycle of latency.
- R8: In both directions, bit 7 of `code_q` equals bit 7 of the source word sampled at the previous edge.
- R9: With the counter selected in the Gray direction and counting, consecutive `code_q` values differ in exactly one bit. This includes the step from code(255) to code(0).
- R10: Decoding the Gray code of any 8-bit value x gives back x, for all 256 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Counter advance enable |
| src_ext | input | 1 | Source select: 0 counter, 1 external word |
| out_bin | input | 1 | Direction select: 0 Gray encode, 1 binary decode |
| ext_code | input | 8 | External source word |
| code_q | output | 8 | Registered converted word |

## Verification
The bench builds the block with its default width of 8. At that width the complete code space can be swept: every one of the 256 values is encoded and decoded, and the counter passes through its 255-to-0 wrap within a few hundred cycles. The single-bit-change property is therefore checked over the full Gray cycle, including the wrap step. Fixed vectors at the two ends of the range and at the MSB boundary are run in all four modes, and a reset in mid-count shows that the counter restarts from zero.

// File: rtl/gxc_pkg.sv
package gxc_pkg;

    // Operating mode = {source select, direction select}
    typedef enum logic [1:0] {
        MODE_CNT_GRAY = 2'b00,
        MODE_CNT_BIN  = 2'b01,
        MODE_EXT_GRAY = 2'b10,
        MODE_EXT_BIN  = 2'b11
    } gxc_mode_e;

endpackage

// File: rtl/gxc_counter.sv
module gxc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] count
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign count = cnt_q;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        en |=> cnt_q == W'($past(cnt_q) + W'(1)));  // R2

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt_q));  // R3

endmodule

// File: rtl/gxc_bin2gray.sv
module gxc_bin2gray #(
    parameter int W = 8
) (
    input  logic [W-1:0] bin,
    output logic [W-1:0] gray
);

    assign gray[W-1] = bin[W-1];

    for (genvar i = 0; i < W - 1; i++) begin : g_bit
        assign gray[i] = bin[i] ^ bin[i+1];
    end

endmodule

// File: rtl/gxc_gray2bin.sv
module gxc_gray2bin #(
    parameter int W = 8
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);

    // Ripple from the MSB down: each decoded bit folds in the one above
    always_comb begin
        logic acc;
        acc      = gray[W-1];
        bin[W-1] = acc;
        for (int i = W - 2; i >= 0; i--) begin
            acc    = acc ^ gray[i];
            bin[i] = acc;
        end
    end

endmodule

// File: rtl/gray_xcoder.sv
module gray_xcoder
    import gxc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic         src_ext,
    input  logic         out_bin,
    input  logic [W-1:0] ext_code,
    output logic [W-1:0] code_q
);

    localparam int MSB = W - 1;

    gxc_mode_e    mode;
    logic [W-1:0] cnt_val;
    logic [W-1:0] src_word;
    logic [W-1:0] enc_word;
    logic [W-1:0] dec_word;
    logic [W-1:0] next_code;

    assign mode = gxc_mode_e'({src_ext, out_bin});

    gxc_counter #(.W(W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .en    (cnt_en),
        .count (cnt_val)
    );

    always_comb begin
        unique case (mode)
            MODE_CNT_GRAY, MODE_CNT_BIN: src_word = cnt_val;
            MODE_EXT_GRAY, MODE_EXT_BIN: src_word = ext_code;
            default:                     src_word = cnt_val;
        endcase
    end

    gxc_bin2gray #(.W(W)) u_enc (
        .bin  (src_word),
        .gray (enc_word)
    );

    gxc_gray2bin #(.W(W)) u_dec (
        .gray (src_word),
        .bin  (dec_word)
    );

    always_comb begin
        unique case (mode)
            MODE_CNT_GRAY, MODE_EXT_GRAY: next_code = enc_word;
            MODE_CNT_BIN,  MODE_EXT_BIN:  next_code = dec_word;
            default:                      next_code = enc_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
        end else begin
            code_q <= next_code;
        end
    end

    AST_MSB_PASS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> code_q[MSB] == $past(src_word[MSB]));  // R8

    AST_GRAY_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CNT_GRAY && $past(mode == MODE_CNT_GRAY && cnt_en && !rst))
        |=> $countones(code_q ^ $past(code_q)) == 1);  // R9

    AST_EXT_FEEDS: assert property (@(posedge clk) disable iff (rst)
        (src_ext && !out_bin) |=> code_q[MSB] == $past(ext_code[MSB]));  // R4

endmodule

// File: tb/gray_xcoder_tb.sv
module gray_xcoder_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cnt_en = 1'b0;
    logic         src_ext = 1'b0;
    logic         out_bin = 1'b0;
    logic [W-1:0] ext_code = '0;
    logic [W-1:0] code_q;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gray_xcoder #(.W(W)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .cnt_en   (cnt_en),
        .src_ext  (src_ext),
        .out_bin  (out_bin),
        .ext_code (ext_code),
        .code_q   (code_q)
    );

    // Vector: {ext word, direction (0 encode / 1 decode), expected}
    localparam logic [16:0] VEC [14] = '{
        {8'h00, 1'b0, 8'h00}, {8'hFF, 1'b0, 8'h80}, {8'h80, 1'b0, 8'hC0},
        {8'h5A, 1'b0, 8'h77}, {8'h01, 1'b0, 8'h01}, {8'h7F, 1'b0, 8'h40},
        {8'h80, 1'b1, 8'hFF}, {8'hFF, 1'b1, 8'hAA}, {8'h77, 1'b1, 8'h5A},
        {8'h40, 1'b1, 8'h7F}, {8'h01, 1'b1, 8'h01}, {8'h00, 1'b1, 8'h00},
        {8'hC0, 1'b1, 8'h80}, {8'h81, 1'b0, 8'hC1}
    };

    function automatic logic [W-1:0] ref_gray(input logic [W-1:0] b);
        logic [W-1:0] g;
        g[W-1] = b[W-1];
        for (int i = 0; i < W - 1; i++) g[i] = b[i] ^ b[i+1];
        return g;
    endfunction

    function automatic logic [W-1:0] ref_bin(input logic [W-1:0] g);
        logic [W-1:0] b;
        b[W-1] = g[W-1];
        for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive_at_neg();
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] model;
        logic [W-1:0] prev;
        logic [W-1:0] g;

        // R1: reset state
        tick();
        tick();
        check("R1 reset clears output", code_q, 8'h00);

        // Vector table, external source: R5 R6 R8 R4
        drive_at_neg();
        rst = 1'b0;
        src_ext = 1'b1;
        for (int k = 0; k < 14; k++) begin
            ext_code = VEC[k][16:9];
            out_bin  = VEC[k][8];
            tick();
            check(VEC[k][8] ? "R6 decode vector" : "R5 encode vector", code_q, VEC[k][7:0]);
            check("R8 msb passes", {7'd0, code_q[W-1]}, {7'd0, VEC[k][16]});
            drive_at_neg();
        end

        // R7: input changed at negedge does not reach output before the edge
        out_bin  = 1'b0;
        ext_code = 8'h5A;
        tick();
        drive_at_neg();
        ext_code = 8'hFF;
        #1;
        check("R7 no change before edge", code_q, 8'h77);
        tick();
        check("R7 updates at edge", code_q, 8'h80);

        // Counter, Gray direction, through wrap: R2 R9 R4
        drive_at_neg();
        rst = 1'b1;
        tick();
        drive_at_neg();
        rst = 1'b0;
        src_ext = 1'b0;
        out_bin = 1'b0;
        cnt_en = 1'b1;
        ext_code = 8'hA5;
        model = '0;
        prev = '0;
        for (int n = 0; n < 260; n++) begin
            tick();
            check("R2 counter gray sequence", code_q, ref_gray(model));
            if (n > 0) begin
                total++;
                if ($countones(code_q ^ prev) != 1) begin
                    bad++;
                    $display("FAIL R9 one-bit step: actual=%02h->%02h expected one bit", prev, code_q);
                end
            end
            prev = code_q;
            model = model + 8'd1;
        end

        // R3: hold
        drive_at_neg();
        cnt_en = 1'b0;
        for (int n = 0; n < 5; n++) begin
            tick();
            check("R3 counter holds", code_q, ref_gray(model));
        end

        // R4/R6: counter source, decode direction
        drive_at_neg();
        out_bin = 1'b1;
        tick();
        check("R4 counter decoded", code_q, ref_bin(model));

        // R1: mid-count reset restarts from zero
        drive_at_neg();
        out_bin = 1'b0;
        cnt_en = 1'b1;
        rst = 1'b1;
        tick();
        check("R1 mid-run reset", code_q, 8'h00);
        drive_at_neg();
        rst = 1'b0;
        tick();
        tick();
        tick();
        check("R1 counter restarted", code_q, ref_gray(8'd2));

        // R10: round trip for every code
        drive_at_neg();
        cnt_en = 1'b0;
        src_ext = 1'b1;
        for (int x = 0; x < 256; x++) begin
            out_bin = 1'b0;
            ext_code = 8'(x);
            tick();
            g = code_q;
            drive_at_neg();
            out_bin = 1'b1;
            ext_code = g;
            tick();
            check("R10 round trip", code_q, 8'(x));
            drive_at_neg();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule